// File: doc/BRIEF.md
# Size-Fitted Buffer Pool Selector

This block chooses a receive buffer for an incoming frame when one ingress port owns several buffer pools of different buffer sizes. A frame-length request arrives on a valid/ready handshake. The selector looks for the pool with the smallest buffer that still holds the whole frame. It then asks an external token manager for one buffer from that pool. When the manager reports that the pool is depleted, the selector moves to the next larger pool. This continues until a buffer token comes back or no larger pool is left.

Each of up to eight pool slots holds a valid bit, a pool identifier and a buffer size in bytes. The pool identifiers start at 0. Software writes the slots in ascending size order. The selector allocates no memory. It only passes on the token (address) that the manager returns, together with the identifier of the pool that supplied it. A failure response tells the requester that no suitable pool could supply a buffer.

Top module: `buf_pool_selector`

## Requirements
- R1: After synchronous reset `req_ready` is 1, and both `rsp_valid` and `acq_valid` are 0.
- R2: The first acquire attempt of a request targets the lowest-index valid slot whose buffer size is greater than or equal to the request length. A size equal to the length counts as a fit.
- R3: When the manager acknowledges with `acq_depleted`=1, the next attempt targets the next higher-index valid slot. Slots whose valid bit is 0 are skipped.
- R4: A slot whose buffer size is smaller than the request length is never attempted, even when every larger slot is depleted.
- R5: When the manager acknowledges with `acq_depleted`=0, the response has `rsp_ok`=1, `rsp_pool_id` equal to the identifier of the slot attempted, and `rsp_addr` equal to `acq_addr` as seen at that acknowledge.
- R6: When all fitting slots are depleted, the response has `rsp_ok`=0. When no slot fits, the response also has `rsp_ok`=0 and no acquire attempt is made.
- R7: `acq_valid` stays high with a stable `acq_pool_id` until `acq_ack`. Only one attempt is outstanding at a time, and none is made while idle.
- R8: A response stays valid with stable fields until `rsp_ready`. `req_ready` is 0 from request acceptance until the cycle after the response is taken, so a request held high during that handshake is accepted one cycle later.
- R9: A write with `cfg_we`=1 replaces slot `cfg_idx` with (`cfg_valid`, `cfg_pool_id`, `cfg_buf_size`). The change applies to every later search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Slot write strobe |
| cfg_idx | input | 3 | Slot index to write |
| cfg_valid | input | 1 | Slot enable |
| cfg_pool_id | input | 6 | Pool identifier of the slot |
| cfg_buf_size | input | 16 | Buffer size of the slot in bytes |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Selector can take a request |
| req_len | input | 16 | Frame length in bytes |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_ok | output | 1 | 1 = buffer obtained, 0 = failure |
| rsp_pool_id | output | 6 | Pool that supplied the buffer |
| rsp_addr | output | 32 | Buffer token returned by the manager |
| acq_valid | output | 1 | Acquire attempt towards the manager |
| acq_pool_id | output | 6 | Pool the attempt targets |
| acq_ack | input | 1 | Manager answers the attempt |
| acq_depleted | input | 1 | Pool had no buffer (valid with ack) |
| acq_addr | input | 32 | Buffer token (valid with ack) |

## Verification
Two events can land on the same clock edge: the requester accepts a response, and a new request is already waiting on `req_valid`. The bench keeps the second request asserted while it raises `rsp_ready`. In the cycle after that handshake it checks that the response is gone and `req_ready` has returned. It then checks that the second request is served correctly. A second overlap is a slot rewrite made between requests. The very next search must skip the slot that was just disabled, or use the slot that was just enabled.

// File: rtl/bps_pkg.sv
package bps_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEARCH = 2'd1,
    ST_ACQ    = 2'd2,
    ST_RESP   = 2'd3
  } bps_state_e;
endpackage

// File: rtl/bps_slot_regs.sv
module bps_slot_regs #(
  parameter int NUM_POOLS = 8,
  parameter int ID_W      = 6,
  parameter int SIZE_W    = 16,
  localparam int IDX_W    = (NUM_POOLS > 1) ? $clog2(NUM_POOLS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic              wvalid,
  input  logic [ID_W-1:0]   wid,
  input  logic [SIZE_W-1:0] wsize,
  output logic              slot_vld  [NUM_POOLS],
  output logic [ID_W-1:0]   slot_id   [NUM_POOLS],
  output logic [SIZE_W-1:0] slot_size [NUM_POOLS]
);
  for (genvar g = 0; g < NUM_POOLS; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        slot_vld[g]  <= 1'b0;
        slot_id[g]   <= '0;
        slot_size[g] <= '0;
      end else if (we && widx == IDX_W'(g)) begin
        slot_vld[g]  <= wvalid;
        slot_id[g]   <= wid;
        slot_size[g] <= wsize;
      end
    end
  end
endmodule

// File: rtl/bps_fit_finder.sv
module bps_fit_finder #(
  parameter int NUM_POOLS = 8,
  parameter int ID_W      = 6,
  parameter int SIZE_W    = 16,
  localparam int IDX_W    = (NUM_POOLS > 1) ? $clog2(NUM_POOLS) : 1,
  localparam int CUR_W    = $clog2(NUM_POOLS + 1)
) (
  input  logic              slot_vld  [NUM_POOLS],
  input  logic [SIZE_W-1:0] slot_size [NUM_POOLS],
  input  logic [SIZE_W-1:0] frame_len,
  input  logic [CUR_W-1:0]  start,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx
);
  logic [NUM_POOLS-1:0] cand;

  // A slot is a candidate if it is enabled, big enough, and not below the cursor.
  for (genvar g = 0; g < NUM_POOLS; g++) begin : g_cand
    assign cand[g] = slot_vld[g] && (slot_size[g] >= frame_len)
                     && (CUR_W'(g) >= start);
  end

  // The lowest-index candidate wins: slots are in ascending size order.
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = NUM_POOLS - 1; i >= 0; i--) begin
      if (cand[i]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/buf_pool_selector.sv
module buf_pool_selector #(
  parameter int NUM_POOLS = 8,
  parameter int ID_W      = 6,
  parameter int SIZE_W    = 16,
  parameter int ADDR_W    = 32,
  localparam int IDX_W    = (NUM_POOLS > 1) ? $clog2(NUM_POOLS) : 1,
  localparam int CUR_W    = $clog2(NUM_POOLS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic              cfg_valid,
  input  logic [ID_W-1:0]   cfg_pool_id,
  input  logic [SIZE_W-1:0] cfg_buf_size,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SIZE_W-1:0] req_len,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_ok,
  output logic [ID_W-1:0]   rsp_pool_id,
  output logic [ADDR_W-1:0] rsp_addr,
  output logic              acq_valid,
  output logic [ID_W-1:0]   acq_pool_id,
  input  logic              acq_ack,
  input  logic              acq_depleted,
  input  logic [ADDR_W-1:0] acq_addr
);
  import bps_pkg::*;

  logic              slot_vld  [NUM_POOLS];
  logic [ID_W-1:0]   slot_id   [NUM_POOLS];
  logic [SIZE_W-1:0] slot_size [NUM_POOLS];

  bps_state_e        state;
  logic [SIZE_W-1:0] len_q;
  logic [CUR_W-1:0]  cursor;
  logic [IDX_W-1:0]  cur_idx;
  logic [SIZE_W-1:0] acq_size_q;
  logic              fit_hit;
  logic [IDX_W-1:0]  fit_idx;

  bps_slot_regs #(.NUM_POOLS(NUM_POOLS), .ID_W(ID_W), .SIZE_W(SIZE_W)) u_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .widx(cfg_idx), .wvalid(cfg_valid),
    .wid(cfg_pool_id), .wsize(cfg_buf_size),
    .slot_vld(slot_vld), .slot_id(slot_id), .slot_size(slot_size)
  );

  bps_fit_finder #(.NUM_POOLS(NUM_POOLS), .ID_W(ID_W), .SIZE_W(SIZE_W)) u_find (
    .slot_vld(slot_vld), .slot_size(slot_size), .frame_len(len_q),
    .start(cursor), .hit(fit_hit), .hit_idx(fit_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      req_ready   <= 1'b1;
      len_q       <= '0;
      cursor      <= '0;
      cur_idx     <= '0;
      acq_valid   <= 1'b0;
      acq_pool_id <= '0;
      acq_size_q  <= '0;
      rsp_valid   <= 1'b0;
      rsp_ok      <= 1'b0;
      rsp_pool_id <= '0;
      rsp_addr    <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (req_valid) begin
            len_q     <= req_len;
            cursor    <= '0;
            req_ready <= 1'b0;
            state     <= ST_SEARCH;
          end
        end
        ST_SEARCH: begin
          if (fit_hit) begin
            cur_idx     <= fit_idx;
            acq_valid   <= 1'b1;
            acq_pool_id <= slot_id[fit_idx];
            acq_size_q  <= slot_size[fit_idx];
            state       <= ST_ACQ;
          end else begin
            rsp_valid   <= 1'b1;
            rsp_ok      <= 1'b0;
            rsp_pool_id <= '0;
            rsp_addr    <= '0;
            state       <= ST_RESP;
          end
        end
        ST_ACQ: begin
          if (acq_ack) begin
            acq_valid <= 1'b0;
            if (acq_depleted) begin
              cursor <= CUR_W'(cur_idx) + CUR_W'(1);
              state  <= ST_SEARCH;
            end else begin
              rsp_valid   <= 1'b1;
              rsp_ok      <= 1'b1;
              rsp_pool_id <= acq_pool_id;
              rsp_addr    <= acq_addr;
              state       <= ST_RESP;
            end
          end
        end
        ST_RESP: begin
          if (rsp_ready) begin
            rsp_valid <= 1'b0;
            req_ready <= 1'b1;
            state     <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_ACQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    acq_valid && !acq_ack |=> acq_valid && $stable(acq_pool_id)); // R7
  AST_NO_ACQ_IDLE: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !acq_valid); // R7
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_ok) && $stable(rsp_pool_id) && $stable(rsp_addr)); // R8
  AST_READY_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(req_ready && rsp_valid)); // R8
  AST_FIT_ONLY: assert property (@(posedge clk) disable iff (rst)
    $rose(acq_valid) |-> acq_size_q >= len_q); // R4
  AST_OK_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    $rose(rsp_valid) && rsp_ok |-> $past(acq_ack) && !$past(acq_depleted)); // R5
endmodule

// File: tb/tb_buf_pool_selector.sv
`timescale 1ns/1ps
module tb_buf_pool_selector;
  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we = 0, cfg_valid = 0;
  logic [2:0]  cfg_idx = 0;
  logic [5:0]  cfg_pool_id = 0;
  logic [15:0] cfg_buf_size = 0;
  logic        req_valid = 0, req_ready;
  logic [15:0] req_len = 0;
  logic        rsp_valid, rsp_ready = 0, rsp_ok;
  logic [5:0]  rsp_pool_id;
  logic [31:0] rsp_addr;
  logic        acq_valid, acq_ack = 0, acq_depleted = 0;
  logic [5:0]  acq_pool_id;
  logic [31:0] acq_addr = 0;

  always #2 clk = ~clk;

  buf_pool_selector dut (.*);

  int checks = 0, errors = 0;
  logic [63:0] dep_mask = '0;
  int lat = 0, wait_cnt = 0, tries = 0, first_id = -1, serial = 0;
  logic [5:0]  held_id;
  logic [31:0] last_addr = 0;
  int min_len = 0, prev_try = -1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Token manager model: answers each attempt after lat idle cycles.
  always @(negedge clk) begin
    if (acq_ack) begin
      acq_ack = 0;
    end else if (acq_valid) begin
      if (wait_cnt == 0) begin
        held_id = acq_pool_id;
        tries++;
        if (first_id < 0) first_id = acq_pool_id;
        // R4 and R3: size of id k is 128<<(k-7); attempts ascend
        check((128 << (acq_pool_id - 7)) >= min_len || acq_pool_id >= 20, "R4", acq_pool_id, min_len);
        check(int'(acq_pool_id) > prev_try, "R3", acq_pool_id, prev_try);
        prev_try = acq_pool_id;
      end else begin
        check(acq_pool_id == held_id, "R7", acq_pool_id, held_id);
      end
      if (wait_cnt >= lat) begin
        acq_ack = 1;
        acq_depleted = dep_mask[acq_pool_id];
        acq_addr = {acq_pool_id, 26'(serial)};
        last_addr = acq_addr;
        serial++;
        wait_cnt = 0;
      end else begin
        wait_cnt++;
      end
    end
  end

  task automatic write_slot(input int idx, input bit v, input int id, input int sz);
    @(negedge clk);
    cfg_we = 1; cfg_idx = 3'(idx); cfg_valid = v; cfg_pool_id = 6'(id); cfg_buf_size = 16'(sz);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic send(input int len);
    tries = 0; first_id = -1; min_len = len; prev_try = -1;
    @(negedge clk);
    req_valid = 1; req_len = 16'(len);
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid) @(negedge clk);
  endtask

  task automatic take;
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
  endtask

  typedef struct packed {
    logic [15:0] len;
    logic [63:0] dep;
    logic        ok;
    logic [5:0]  id;
    logic [3:0]  ntry;
    logic [5:0]  first;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{16'd100,  64'h0,                 1'b1, 6'd7,  4'd1, 6'd7},
    '{16'd128,  64'h0,                 1'b1, 6'd7,  4'd1, 6'd7},
    '{16'd129,  64'h0,                 1'b1, 6'd8,  4'd1, 6'd8},
    '{16'd300,  64'h200,               1'b1, 6'd10, 4'd2, 6'd9},
    '{16'd300,  64'hE00,               1'b1, 6'd12, 4'd4, 6'd9},
    '{16'd300,  64'h1E00,              1'b0, 6'd0,  4'd4, 6'd9},
    '{16'd5000, 64'h0,                 1'b0, 6'd0,  4'd0, 6'd0},
    '{16'd4096, 64'h0,                 1'b1, 6'd12, 4'd1, 6'd12},
    '{16'd1,    64'h80,                1'b1, 6'd8,  4'd2, 6'd7},
    '{16'd2000, 64'h780,               1'b1, 6'd11, 4'd1, 6'd11}
  };

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(req_ready == 1, "R1", req_ready, 1);
    check(rsp_valid == 0, "R1", rsp_valid, 0);
    check(acq_valid == 0, "R1", acq_valid, 0);

    // Slots 0..5: ids 7..12, sizes 128..4096; slots 6,7 disabled (R9)
    for (int i = 0; i < 6; i++) write_slot(i, 1, 7 + i, 128 << i);

    foreach (VECS[k]) begin
      dep_mask = VECS[k].dep;
      send(int'(VECS[k].len));
      check(rsp_ok == VECS[k].ok, "R6", rsp_ok, VECS[k].ok);
      if (VECS[k].ok) begin
        check(rsp_pool_id == VECS[k].id, "R5", rsp_pool_id, VECS[k].id);
        check(rsp_addr == last_addr, "R5", rsp_addr, last_addr);
      end
      check(tries == int'(VECS[k].ntry), "R3", tries, VECS[k].ntry);
      if (VECS[k].ntry != 0)
        check(first_id == int'(VECS[k].first), "R2", first_id, VECS[k].first);
      take();
    end
    dep_mask = '0;

    // R8: response held while not taken; request blocked
    lat = 3;
    send(700);
    repeat (3) begin
      @(negedge clk);
      check(rsp_valid == 1 && rsp_pool_id == 10, "R8", rsp_pool_id, 10);
      check(req_ready == 0, "R8", req_ready, 0);
    end
    check(tries == 1, "R7", tries, 1);
    lat = 0;

    // R8: new request waiting while the response is taken
    req_valid = 1; req_len = 16'd200;
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    check(rsp_valid == 0, "R8", rsp_valid, 0);
    check(req_ready == 1, "R8", req_ready, 1);
    tries = 0; first_id = -1; min_len = 200; prev_try = -1;
    @(negedge clk);
    req_valid = 0;
    while (!rsp_valid) @(negedge clk);
    check(rsp_ok && rsp_pool_id == 8, "R8", rsp_pool_id, 8);
    take();

    // R9: disable slot 2, the 512-byte pool is skipped
    write_slot(2, 0, 9, 512);
    send(300);
    check(first_id == 10 && rsp_pool_id == 10, "R9", first_id, 10);
    take();
    // R9: enable slot 6 with a large pool
    write_slot(6, 1, 20, 8192);
    send(6000);
    check(rsp_ok && rsp_pool_id == 20, "R9", rsp_pool_id, 20);
    take();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule